// File: doc/BRIEF.md
# CF-ATA Host Address Remapper

This block sits between the host side of a removable-card slot (common-memory or I/O cycles) and the task-file register port of an ATA drive model. Each host access carries an offset. The block folds that offset onto a 16-entry register map, using one of four addressing modes chosen by a configuration input. It then either forwards the access to the drive as a task-file index with a read or write strobe, or serves the access itself.

The block serves five kinds of access by itself:
- Byte-wide data accesses. A toggling byte-cycle flag and a word latch pair two 8-bit accesses into one 16-bit transfer.
- The odd data byte, at index 9.
- The alternate-status read, at index 14.
- The device-control write, also at index 14. It is held on an output, and its soft-reset bit raises a one-cycle reset request.
- A device-address value built from the drive's select bits.

A forwarded write that arrives while the card is powered down wakes it.

All decode is combinational within the access cycle. Only the byte latch, the byte-cycle flag and the device-control value are registered.

Top module: `cfata_addr_remap`

## Requirements
- R1: With `cfg_mode` = 0 (memory map), every offset in 0x400–0x7FF selects index 0, and other offsets pass unchanged. After remapping in any mode, an offset of 16 or more is a miss: it raises no task-file strobe and reads as zero.
- R2: With `cfg_mode` = 1 (contiguous I/O), the index is bits [3:0] of the offset, whatever the upper bits.
- R3: With `cfg_mode` = 2 (primary I/O), offsets in the 16-byte block at 0x1F0 are reduced by 0x1F0, and offsets in the block at 0x3F0 are reduced by 0x3E8. Other offsets pass unchanged.
- R4: With `cfg_mode` = 3 (secondary I/O), offsets in the 16-byte block at 0x170 are reduced by 0x170, and offsets in the block at 0x370 are reduced by 0x368.
- R5: A word access (`host_byte` = 0) at index 0 or 8 is forwarded as task-file index 0, with the full 16-bit data in both directions.
- R6: A byte read (`host_byte` = 1) at index 0 or 8 behaves according to the byte-cycle flag:
  - Flag clear: it fetches one word from task-file index 0, latches it and returns its low byte.
  - Flag set: it returns the latched high byte and makes no task-file read.
  - Each such access toggles the flag.
- R7: A byte write at index 0 or 8 behaves according to the byte-cycle flag:
  - Flag clear: it latches the low byte and makes no task-file write.
  - Flag set: it issues one write to index 0 with data {new byte, latched byte}.
  - Each such access toggles the flag.
- R8: Index 9 handles the odd data byte. A read returns the latched high byte without a task-file access. A write stores the byte into the latch's low half and toggles the byte-cycle flag.
- R9: Index 13 is forwarded as task-file index 1, for both reads and writes.
- R10: A read at index 14 returns `drv_status` when `drv_present` is 1, and zero otherwise. A write at index 14 stores its low byte on `devctl` and raises no task-file strobe.
- R11: A write at index 14 with bit 2 set raises `srst_req` during that access. In the next cycle, `devctl` is 0 and the byte-cycle flag is clear.
- R12: A read at index 15 returns 0xC2 OR ((NOT `drv_sel`) shifted left by 2, masked to bits 5..2). It makes no task-file access.
- R13: A write forwarded to any index other than 0, 8, 9, 13 or 14 raises `wake` while `pwrdn` is 1, and is still forwarded with its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Addressing mode: 0 memory, 1 contiguous, 2 primary, 3 secondary |
| host_rd | input | 1 | Host read in this cycle |
| host_wr | input | 1 | Host write in this cycle |
| host_byte | input | 1 | Access is 8 bits wide |
| host_addr | input | ADDR_W (12) | Host offset from the window base |
| host_wdata | input | DATA_W (16) | Host write data |
| host_rdata | output | DATA_W (16) | Host read data, valid in the access cycle |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_idx | output | 4 | Task-file register index |
| tf_wdata | output | DATA_W (16) | Task-file write data |
| tf_rdata | input | DATA_W (16) | Task-file read data, combinational from tf_idx |
| drv_present | input | 1 | A drive is attached |
| drv_status | input | 8 | Drive status byte |
| drv_sel | input | 4 | Drive select bits used for the address register |
| pwrdn | input | 1 | Card is in power-down |
| wake | output | 1 | Clear power-down and set card-ready |
| srst_req | output | 1 | Full card reset request |
| devctl | output | 8 | Last device-control value |

## Verification
The byte-cycle flag and the word latch are hidden, so a wrong value shows up at the ports only on the next byte access. A flag in the wrong phase shows one access later: a task-file read where none belongs, a missing task-file write, or the two bytes swapped in the assembled word. The bench therefore chains byte accesses across the odd-byte index and across a soft reset, and checks strobes and data on every access of each chain. Decode faults are visible at once, as a wrong `tf_idx` or a strobe on a miss in the same cycle. The registered `devctl` is checked one cycle after its write.

// File: rtl/cfata_remap_pkg.sv
package cfata_remap_pkg;

   typedef enum logic [1:0] {
      MODE_MEM    = 2'd0,
      MODE_CONTIG = 2'd1,
      MODE_PRI    = 2'd2,
      MODE_SEC    = 2'd3
   } addr_mode_e;

   localparam int IDX_W    = 4;
   localparam int MAP_SIZE = 1 << IDX_W;
   localparam int CTL_W    = 8;
   localparam int SRST_BIT = 2;

   localparam logic [IDX_W-1:0] IDX_DATA     = 4'h0;
   localparam logic [IDX_W-1:0] IDX_DATA_ALT = 4'h8;
   localparam logic [IDX_W-1:0] IDX_ODD      = 4'h9;
   localparam logic [IDX_W-1:0] IDX_ERRFEAT  = 4'hD;
   localparam logic [IDX_W-1:0] IDX_CTL      = 4'hE;
   localparam logic [IDX_W-1:0] IDX_DEVADDR  = 4'hF;
   localparam logic [IDX_W-1:0] TF_ERRFEAT   = 4'h1;

   localparam logic [7:0] DEVADDR_BASE = 8'hC2;

endpackage

// File: rtl/cfata_remap_decode.sv
module cfata_remap_decode
   import cfata_remap_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int MEM_DATA_BASE = 'h400,
   parameter int MEM_WIN_MASK  = 'h3FF,
   parameter int PRI_CMD_BASE  = 'h1F0,
   parameter int PRI_CTL_BASE  = 'h3F0,
   parameter int PRI_CTL_ADJ   = 'h3E8,
   parameter int SEC_CMD_BASE  = 'h170,
   parameter int SEC_CTL_BASE  = 'h370,
   parameter int SEC_CTL_ADJ   = 'h368
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(MAP_SIZE - 1);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(MAP_SIZE - 1);

   if (ADDR_W < 11) begin : g_chk_addr
      $error("cfata_remap_decode: ADDR_W must cover the 0x400-0x7FF window");
   end

   logic [ADDR_W-1:0] cand [4];
   logic [ADDR_W-1:0] picked;

   for (genvar m = 0; m < 4; m++) begin : g_mode
      if (m == 0) begin : g_mem
         assign cand[m] = ((addr & ~ADDR_W'(MEM_WIN_MASK)) == ADDR_W'(MEM_DATA_BASE))
                          ? '0 : addr;
      end else if (m == 1) begin : g_contig
         assign cand[m] = addr & LOW_MASK;
      end else begin : g_legacy
         localparam int CMD_B = (m == 2) ? PRI_CMD_BASE : SEC_CMD_BASE;
         localparam int CTL_B = (m == 2) ? PRI_CTL_BASE : SEC_CTL_BASE;
         localparam int CTL_A = (m == 2) ? PRI_CTL_ADJ  : SEC_CTL_ADJ;
         logic [ADDR_W-1:0] blk;
         assign blk = addr & BLK_MASK;
         assign cand[m] = (blk == ADDR_W'(CTL_B)) ? addr - ADDR_W'(CTL_A) :
                          (blk == ADDR_W'(CMD_B)) ? addr - ADDR_W'(CMD_B) :
                          addr;
      end
   end

   assign picked = cand[mode];
   assign hit    = (picked & BLK_MASK) == '0;
   assign idx    = picked[IDX_W-1:0];

endmodule

// File: rtl/cfata_byte_lane.sv
module cfata_byte_lane #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              byte_rd,
   input  logic              byte_wr,
   input  logic              odd_wr,
   input  logic [DATA_W-1:0] word_in,
   input  logic [DATA_W/2-1:0] wbyte,
   output logic              word_rd,
   output logic              word_wr,
   output logic [DATA_W-1:0] word_out,
   output logic [DATA_W/2-1:0] rd_byte,
   output logic [DATA_W/2-1:0] odd_byte
);

   localparam int BYTE_W = DATA_W / 2;

   logic              cycle_q;
   logic [DATA_W-1:0] latch_q;
   logic              any_acc;

   assign any_acc  = byte_rd | byte_wr | odd_wr;
   assign word_rd  = byte_rd & ~cycle_q;
   assign word_wr  = byte_wr & cycle_q;
   assign word_out = {wbyte, latch_q[BYTE_W-1:0]};
   assign rd_byte  = cycle_q ? latch_q[DATA_W-1:BYTE_W] : word_in[BYTE_W-1:0];
   assign odd_byte = latch_q[DATA_W-1:BYTE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cycle_q <= 1'b0;
         latch_q <= '0;
      end else begin
         if (clr)          cycle_q <= 1'b0;
         else if (any_acc) cycle_q <= ~cycle_q;
         if (byte_rd && !cycle_q) latch_q <= word_in;
         if ((byte_wr && !cycle_q) || odd_wr) latch_q[BYTE_W-1:0] <= wbyte;
      end
   end

   // R6 / R7 / R8: every paired or odd byte access flips the phase
   a_r6_cycle_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (any_acc && !clr) |=> (cycle_q != $past(cycle_q)));

   // R11: a soft reset leaves the phase clear
   a_r11_cycle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !cycle_q);

   // R7: a paired write keeps the stored low byte in the assembled word
   a_r7_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && !cycle_q && !clr) |=> (latch_q[BYTE_W-1:0] == $past(wbyte)));

endmodule

// File: rtl/cfata_devctl.sv
module cfata_devctl
   import cfata_remap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] devctl,
   output logic             srst_req
);

   assign srst_req = wr & wdata[SRST_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)        devctl <= '0;
      else if (srst_req) devctl <= '0;
      else if (wr)       devctl <= wdata;
   end

   // R11: reset request leaves device control cleared
   a_r11_devctl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      srst_req |=> (devctl == '0));

   // R10: a plain control write is held
   a_r10_devctl_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wdata[SRST_BIT]) |=> (devctl == $past(wdata)));

endmodule

// File: rtl/cfata_addr_remap.sv
module cfata_addr_remap
   import cfata_remap_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic              host_byte,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              tf_rd,
   output logic              tf_wr,
   output logic [3:0]        tf_idx,
   output logic [DATA_W-1:0] tf_wdata,
   input  logic [DATA_W-1:0] tf_rdata,
   input  logic              drv_present,
   input  logic [7:0]        drv_status,
   input  logic [3:0]        drv_sel,
   input  logic              pwrdn,
   output logic              wake,
   output logic              srst_req,
   output logic [7:0]        devctl
);

   localparam int BYTE_W = DATA_W / 2;

   if ((DATA_W % 2) != 0 || DATA_W < 16) begin : g_chk_data
      $error("cfata_addr_remap: DATA_W must be even and at least 16");
   end

   logic [IDX_W-1:0] idx;
   logic             hit;
   logic             rd, wr;
   logic             is_data, is_odd, is_ef, is_ctl, is_addr, is_fwd;
   logic             lane_brd, lane_bwr, lane_owr;
   logic             lane_wrd, lane_wwr;
   logic [DATA_W-1:0] lane_word;
   logic [BYTE_W-1:0] lane_rbyte, lane_obyte;
   logic [7:0]        addr_val;

   cfata_remap_decode #(.ADDR_W(ADDR_W)) u_decode (
      .mode (cfg_mode),
      .addr (host_addr),
      .idx  (idx),
      .hit  (hit)
   );

   assign rd = host_rd & hit;
   assign wr = host_wr & hit;

   assign is_data = (idx == IDX_DATA) || (idx == IDX_DATA_ALT);
   assign is_odd  = (idx == IDX_ODD);
   assign is_ef   = (idx == IDX_ERRFEAT);
   assign is_ctl  = (idx == IDX_CTL);
   assign is_addr = (idx == IDX_DEVADDR);
   assign is_fwd  = ~(is_data | is_odd | is_ef | is_ctl);

   assign lane_brd = rd & is_data & host_byte;
   assign lane_bwr = wr & is_data & host_byte;
   assign lane_owr = wr & is_odd;

   cfata_byte_lane #(.DATA_W(DATA_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst_req),
      .byte_rd  (lane_brd),
      .byte_wr  (lane_bwr),
      .odd_wr   (lane_owr),
      .word_in  (tf_rdata),
      .wbyte    (host_wdata[BYTE_W-1:0]),
      .word_rd  (lane_wrd),
      .word_wr  (lane_wwr),
      .word_out (lane_word),
      .rd_byte  (lane_rbyte),
      .odd_byte (lane_obyte)
   );

   cfata_devctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr & is_ctl),
      .wdata    (host_wdata[CTL_W-1:0]),
      .devctl   (devctl),
      .srst_req (srst_req)
   );

   assign addr_val = DEVADDR_BASE | {2'b00, ~drv_sel, 2'b00};

   always_comb begin
      tf_rd = (rd & is_data & ~host_byte) | lane_wrd | (rd & is_ef)
            | (rd & is_fwd & ~is_addr);
      tf_wr = (wr & is_data & ~host_byte) | lane_wwr | (wr & is_ef)
            | (wr & is_fwd);
      if (is_data || is_odd) tf_idx = IDX_DATA;
      else if (is_ef)        tf_idx = TF_ERRFEAT;
      else                   tf_idx = idx;
      tf_wdata = lane_wwr ? lane_word : host_wdata;
   end

   always_comb begin
      host_rdata = '0;
      if (rd) begin
         if (is_data)      host_rdata = host_byte ? DATA_W'(lane_rbyte) : tf_rdata;
         else if (is_odd)  host_rdata = DATA_W'(lane_obyte);
         else if (is_ctl)  host_rdata = drv_present ? DATA_W'(drv_status) : '0;
         else if (is_addr) host_rdata = DATA_W'(addr_val);
         else              host_rdata = tf_rdata;
      end
   end

   assign wake = wr & is_fwd & pwrdn;

   // R1: a miss never reaches the drive and reads as zero
   a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_rd || host_wr) && !hit) |-> (!tf_rd && !tf_wr && host_rdata == '0));

   // R5: one direction at a time toward the drive
   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && host_wr) |-> $onehot0({tf_rd, tf_wr}));

   // R10: a control write stays inside the block
   a_r10_ctl_local: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && hit && idx == IDX_CTL) |-> !tf_wr);

   // R13: wake only accompanies a forwarded write
   a_r13_wake_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (tf_wr && tf_idx == idx && pwrdn));

endmodule

// File: tb/cfata_addr_remap_tb.sv
module cfata_addr_remap_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  cfg_mode;
   logic        host_rd, host_wr, host_byte;
   logic [11:0] host_addr;
   logic [15:0] host_wdata, host_rdata;
   logic        tf_rd, tf_wr;
   logic [3:0]  tf_idx;
   logic [15:0] tf_wdata, tf_rdata;
   logic        drv_present;
   logic [7:0]  drv_status;
   logic [3:0]  drv_sel;
   logic        pwrdn, wake, srst_req;
   logic [7:0]  devctl;

   logic [15:0] tf_mem [16];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [15:0] c_rdata, c_wdata;
   logic        c_rd, c_wr, c_srst, c_wake;
   logic [3:0]  c_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign tf_rdata = tf_mem[tf_idx];

   cfata_addr_remap u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .host_rd(host_rd), .host_wr(host_wr), .host_byte(host_byte),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_idx(tf_idx), .tf_wdata(tf_wdata),
      .tf_rdata(tf_rdata), .drv_present(drv_present), .drv_status(drv_status),
      .drv_sel(drv_sel), .pwrdn(pwrdn), .wake(wake), .srst_req(srst_req),
      .devctl(devctl)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic acc(input logic r, input logic w, input logic b,
                      input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      host_rd = r; host_wr = w; host_byte = b; host_addr = a; host_wdata = d;
      #1;
      c_rdata = host_rdata; c_rd = tf_rd; c_wr = tf_wr; c_idx = tf_idx;
      c_wdata = tf_wdata; c_srst = srst_req; c_wake = wake;
      @(posedge clk);
      #1;
      host_rd = 0; host_wr = 0; host_byte = 0;
   endtask

   task automatic t_reset;
      #1;
      chk(devctl == 8'h00, "R11 reset devctl", devctl, 0);
      chk(host_rdata == 16'h0 && !tf_rd && !tf_wr, "R1 idle quiet",
          {host_rdata, tf_rd, tf_wr}, 0);
   endtask

   task automatic t_mem_mode;
      cfg_mode = 2'd0;
      acc(1, 0, 0, 12'h400, 0);
      chk(c_rd && c_idx == 0 && c_rdata == 16'hA000, "R1 0x400 to data",
          {c_idx, c_rdata}, {4'h0, 16'hA000});
      acc(1, 0, 0, 12'h7FE, 0);
      chk(c_rd && c_idx == 0, "R1 0x7FE to data", c_idx, 0);
      acc(1, 0, 0, 12'h003, 0);
      chk(c_rd && c_idx == 3 && c_rdata == 16'hA003, "R1 pass-through",
          {c_idx, c_rdata}, {4'h3, 16'hA003});
      acc(1, 0, 0, 12'h020, 0);
      chk(!c_rd && c_rdata == 0, "R1 miss read", {c_rd, c_rdata}, 0);
      acc(0, 1, 0, 12'h800, 16'h1234);
      chk(!c_wr, "R1 miss write", c_wr, 0);
   endtask

   task automatic t_contig_mode;
      cfg_mode = 2'd1;
      acc(1, 0, 0, 12'h125, 0);
      chk(c_rd && c_idx == 5 && c_rdata == 16'hA005, "R2 low nibble",
          c_idx, 5);
      acc(1, 0, 0, 12'hAB7, 0);
      chk(c_rd && c_idx == 7, "R2 high bits dropped", c_idx, 7);
   endtask

   task automatic t_pri_mode;
      cfg_mode = 2'd2;
      acc(1, 0, 0, 12'h1F7, 0);
      chk(c_rd && c_idx == 7, "R3 command block", c_idx, 7);
      drv_present = 1; drv_status = 8'h58;
      acc(1, 0, 0, 12'h3F6, 0);
      chk(!c_rd && c_rdata == 16'h0058, "R3 control block alt status",
          c_rdata, 16'h58);
      acc(0, 1, 0, 12'h1F2, 16'h0077);
      chk(c_wr && c_idx == 2 && c_wdata == 16'h0077, "R3 write remap",
          {c_idx, c_wdata}, {4'h2, 16'h0077});
      acc(1, 0, 0, 12'h3FA, 0);
      chk(!c_rd && c_rdata == 0, "R3 beyond map is miss", c_rdata, 0);
   endtask

   task automatic t_sec_mode;
      cfg_mode = 2'd3;
      acc(1, 0, 0, 12'h172, 0);
      chk(c_rd && c_idx == 2, "R4 command block", c_idx, 2);
      acc(1, 0, 0, 12'h376, 0);
      chk(!c_rd && c_rdata == 16'h0058, "R4 control block", c_rdata, 16'h58);
      drv_sel = 4'h0;
      acc(1, 0, 0, 12'h377, 0);
      chk(!c_rd && c_rdata == 16'h00FE, "R12 sel 0", c_rdata, 16'hFE);
      drv_sel = 4'hA;
      acc(1, 0, 0, 12'h377, 0);
      chk(c_rdata == 16'h00D6, "R12 sel A", c_rdata, 16'hD6);
   endtask

   task automatic t_word_data;
      cfg_mode = 2'd1;
      acc(0, 1, 0, 12'h008, 16'hCAFE);
      chk(c_wr && c_idx == 0 && c_wdata == 16'hCAFE, "R5 word write alt",
          {c_idx, c_wdata}, {4'h0, 16'hCAFE});
      acc(1, 0, 0, 12'h000, 0);
      chk(c_rd && c_rdata == 16'hCAFE, "R5 word read", c_rdata, 16'hCAFE);
   endtask

   task automatic t_byte_data;
      cfg_mode = 2'd1;
      tf_mem[0] = 16'hBEEF;
      acc(1, 0, 1, 12'h000, 0);
      chk(c_rd && c_idx == 0 && c_rdata == 16'h00EF, "R6 first byte read",
          {c_rd, c_rdata}, {1'b1, 16'hEF});
      acc(1, 0, 1, 12'h008, 0);
      chk(!c_rd && c_rdata == 16'h00BE, "R6 second byte read",
          {c_rd, c_rdata}, {1'b0, 16'hBE});
      acc(0, 1, 1, 12'h000, 16'h0011);
      chk(!c_wr, "R7 first byte write held", c_wr, 0);
      acc(0, 1, 1, 12'h000, 16'h0022);
      chk(c_wr && c_idx == 0 && c_wdata == 16'h2211, "R7 paired write",
          {c_wr, c_wdata}, {1'b1, 16'h2211});
   endtask

   task automatic t_odd_byte;
      cfg_mode = 2'd1;
      acc(1, 0, 0, 12'h009, 0);
      chk(!c_rd && c_rdata == 16'h00BE, "R8 odd read", c_rdata, 16'hBE);
      acc(0, 1, 0, 12'h009, 16'h0033);
      chk(!c_wr, "R8 odd write local", c_wr, 0);
      acc(0, 1, 1, 12'h000, 16'h0044);
      chk(c_wr && c_wdata == 16'h4433, "R8 odd write pairs", c_wdata, 16'h4433);
   endtask

   task automatic t_errfeat;
      cfg_mode = 2'd1;
      acc(1, 0, 0, 12'h00D, 0);
      chk(c_rd && c_idx == 1 && c_rdata == 16'hA001, "R9 error read",
          {c_idx, c_rdata}, {4'h1, 16'hA001});
      acc(0, 1, 0, 12'h00D, 16'h0003);
      chk(c_wr && c_idx == 1, "R9 features write", c_idx, 1);
   endtask

   task automatic t_ctl;
      cfg_mode = 2'd1;
      drv_present = 0;
      acc(1, 0, 0, 12'h00E, 0);
      chk(c_rdata == 0, "R10 no drive status zero", c_rdata, 0);
      drv_present = 1; drv_status = 8'h50;
      acc(1, 0, 0, 12'h00E, 0);
      chk(c_rdata == 16'h0050, "R10 alt status", c_rdata, 16'h50);
      acc(0, 1, 0, 12'h00E, 16'h0002);
      chk(!c_wr && !c_srst && devctl == 8'h02, "R10 devctl write",
          {c_wr, devctl}, 8'h02);
   endtask

   task automatic t_srst;
      cfg_mode = 2'd1;
      tf_mem[0] = 16'h1357;
      acc(1, 0, 1, 12'h000, 0);
      acc(0, 1, 0, 12'h00E, 16'h0006);
      chk(c_srst, "R11 reset request", c_srst, 1);
      chk(devctl == 8'h00, "R11 devctl cleared", devctl, 0);
      acc(1, 0, 1, 12'h000, 0);
      chk(c_rd && c_rdata == 16'h0057, "R11 byte phase cleared",
          {c_rd, c_rdata}, {1'b1, 16'h57});
      acc(1, 0, 1, 12'h000, 0);
   endtask

   task automatic t_wake;
      cfg_mode = 2'd1;
      pwrdn = 1;
      acc(0, 1, 0, 12'h003, 16'h0009);
      chk(c_wake && c_wr && c_idx == 3, "R13 wake on forwarded write",
          {c_wake, c_wr, c_idx}, {1'b1, 1'b1, 4'h3});
      acc(0, 1, 0, 12'h00D, 16'h0001);
      chk(!c_wake && c_wr, "R13 no wake on features", c_wake, 0);
      acc(0, 1, 0, 12'h00F, 16'h0001);
      chk(c_wake && c_idx == 15, "R13 wake on index 15", c_wake, 1);
      pwrdn = 0;
      acc(0, 1, 0, 12'h004, 16'h0001);
      chk(!c_wake && c_wr, "R13 no wake when awake", c_wake, 0);
   endtask

   initial begin
      for (int k = 0; k < 16; k++) tf_mem[k] = 16'hA000 | 16'(k);
      rst_n = 0; cfg_mode = 0; host_rd = 0; host_wr = 0; host_byte = 0;
      host_addr = 0; host_wdata = 0; drv_present = 0; drv_status = 0;
      drv_sel = 0; pwrdn = 0;
      repeat (3) @(posedge clk);
      rst_n = 1;
      t_reset();
      t_mem_mode();
      t_contig_mode();
      t_pri_mode();
      t_sec_mode();
      t_word_data();
      t_byte_data();
      t_odd_byte();
      t_errfeat();
      t_ctl();
      t_srst();
      t_wake();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   always @(posedge clk) begin
      if (tf_wr) tf_mem[tf_idx] <= tf_wdata;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule